// File: doc/BRIEF.md
# Task Dependency Tracking Queue

This block holds task descriptors posted by several applications and decides when each of them may be issued to a processing element. Each descriptor carries an owning application, a priority and up to sixteen memory regions. Each region is a base address and a byte length, flagged as read (input) or written (output). When a descriptor is accepted, the block returns a task identifier. Later descriptors can name that identifier as a predecessor. When the issued task finishes, the consumer quotes the identifier on the completion port.

Three ordering policies are chosen per descriptor through `cfg_mode`. With no checking, a task may issue at once. With explicit ordering, the task waits for up to two named identifiers that are still resident. With runtime checking, the new task's regions are compared against every resident task, one resident slot per clock. The task then waits for every slot that its regions conflict with. Issue always goes to the highest-priority ready task, and within one priority the oldest task goes first. Each application may hold only a limited number of tasks. A per-application sync request is acknowledged once that application holds none.

Top module: `task_dep_queue`

## Requirements
- R1: Two regions overlap only when each base is below the other's exclusive end (base plus length). A region of length zero never overlaps anything, and two adjacent regions do not overlap.
- R2: With runtime checking (`cfg_mode` = 2), a new task waits for a resident task in two cases: one of its inputs overlaps an output of that task, or one of its outputs overlaps any region of that task. Input-on-input overlap adds no wait. The task becomes issuable the cycle after its last such predecessor completes.
- R3: After a runtime-checked descriptor is accepted, `in_ready` stays low for exactly SLOTS cycles. The new task cannot issue during that scan.
- R4: With no checking (`cfg_mode` = 0), an accepted task is offered for issue in the next cycle, even if its regions overlap those of resident tasks.
- R5: With explicit ordering (`cfg_mode` = 1), a task waits for each identifier in `in_dep_ids` whose bit in `in_dep_vld` is set and that belongs to a resident task. Bit 0 selects bits [ID_W-1:0] and bit 1 selects bits [2*ID_W-1:ID_W]. An identifier that is not resident adds no wait.
- R6: `in_id` gives the identifier of the descriptor being accepted. Identifiers start at 0 after reset and increase by one for each accepted descriptor.
- R7: `in_ready` is low while the application on `in_app` holds APP_DEPTH tasks that have not completed. Other applications are not affected.
- R8: The task offered on `disp_id` has the highest `in_prio` value among ready tasks. Among ready tasks of equal priority, the earliest accepted is offered.
- R9: A completion frees a task only if its identifier matches a task that has already been issued. Any other completion changes nothing.
- R10: `sync_ack[a]` is high exactly when `sync_req[a]` is high and application a holds no task. This includes the state right after reset.
- R11: After reset, `in_ready` is high and `disp_valid` is low.
- R12: A task is issued once. After its handshake it is not offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Ordering policy for the descriptor being accepted (0 none, 1 explicit, 2 runtime) |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor can be accepted |
| in_app | input | $clog2(NAPP) | Owning application |
| in_prio | input | PRIO_W | Priority, larger is more urgent |
| in_dep_ids | input | 2*ID_W | Two explicit predecessor identifiers |
| in_dep_vld | input | 2 | Enables for the two predecessor identifiers |
| in_base | input | NREG*32 | Region base addresses, region r in bits [32r+31:32r] |
| in_size | input | NREG*16 | Region lengths in bytes, region r in bits [16r+15:16r] |
| in_is_out | input | NREG | Region r is an output when bit r is set |
| in_id | output | ID_W | Identifier given to the accepted descriptor |
| done_valid | input | 1 | Completion present |
| done_id | input | ID_W | Identifier of the completed task |
| disp_valid | output | 1 | A task is offered for issue |
| disp_ready | input | 1 | Consumer takes the offered task |
| disp_id | output | ID_W | Identifier of the offered task |
| disp_app | output | $clog2(NAPP) | Application of the offered task |
| sync_req | input | NAPP | Per-application sync request |
| sync_ack | output | NAPP | Per-application sync acknowledge |

## Verification
Suppose a wait bit is set or cleared wrongly. Either a task appears on `disp_valid` while its predecessor is still running, or a task never appears after its predecessor's completion. The bench sees this at the first sampling point after the completion. If the age or priority state is corrupt, the order of identifiers on the issue port is wrong, so each scenario checks issue order and not just the set of issued tasks. A per-application count that drifts shows up as `in_ready` held low too early, or as `sync_ack` rising while that application still has a task.

// File: rtl/tdq_pkg.sv
package tdq_pkg;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 16;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SIZE_W-1:0] size_t;

  typedef enum logic [1:0] {
    CHK_NONE     = 2'd0,
    CHK_EXPLICIT = 2'd1,
    CHK_RUNTIME  = 2'd2
  } chk_mode_e;

  // Half-open spans [base, base+len); ends are computed one bit wider so they cannot wrap.
  function automatic logic span_overlap(input addr_t a_base, input size_t a_len,
                                        input addr_t b_base, input size_t b_len);
    logic [ADDR_W:0] a_end;
    logic [ADDR_W:0] b_end;
    a_end = {1'b0, a_base} + {{(ADDR_W+1-SIZE_W){1'b0}}, a_len};
    b_end = {1'b0, b_base} + {{(ADDR_W+1-SIZE_W){1'b0}}, b_len};
    return (a_len != '0) && (b_len != '0) &&
           ({1'b0, a_base} < b_end) && ({1'b0, b_base} < a_end);
  endfunction

  // An overlap orders two tasks unless both sides only read.
  function automatic logic pair_orders(input logic new_writes, input logic old_writes);
    return new_writes | old_writes;
  endfunction
endpackage

// File: rtl/tdq_conflict.sv
module tdq_conflict
  import tdq_pkg::*;
#(
  parameter int NREG = 16
) (
  input  addr_t           new_base [NREG],
  input  size_t           new_len  [NREG],
  input  logic [NREG-1:0] new_wr,
  input  addr_t           old_base [NREG],
  input  size_t           old_len  [NREG],
  input  logic [NREG-1:0] old_wr,
  output logic            hit
);
  localparam int PAIRS = NREG * NREG;
  logic [PAIRS-1:0] pair_hit;

  for (genvar r = 0; r < NREG; r++) begin : g_new
    for (genvar s = 0; s < NREG; s++) begin : g_old
      assign pair_hit[r*NREG+s] = pair_orders(new_wr[r], old_wr[s]) &&
                                  span_overlap(new_base[r], new_len[r], old_base[s], old_len[s]);
    end
  end

  assign hit = |pair_hit;
endmodule

// File: rtl/tdq_pick.sv
module tdq_pick #(
  parameter int SLOTS  = 8,
  parameter int PRIO_W = 2,
  localparam int SI_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOTS-1:0]  req,
  input  logic [PRIO_W-1:0] prio  [SLOTS],
  input  logic [SLOTS-1:0]  older [SLOTS],
  output logic [SLOTS-1:0]  grant,
  output logic [SI_W-1:0]   grant_idx,
  output logic              any
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_cand
    logic beats_all;
    always_comb begin
      beats_all = 1'b1;
      for (int j = 0; j < SLOTS; j++) begin
        if (j != i && req[j]) begin
          if (prio[j] > prio[i]) beats_all = 1'b0;
          else if (prio[j] == prio[i] && !older[i][j]) beats_all = 1'b0;
        end
      end
    end
    assign grant[i] = req[i] && beats_all;
  end

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < SLOTS; i++)
      if (grant[i]) grant_idx = SI_W'(i);
  end

  assign any = |grant;

  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_from_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> any);
endmodule

// File: rtl/tdq_app_count.sv
module tdq_app_count #(
  parameter int NAPP  = 2,
  parameter int DEPTH = 4,
  localparam int AP_W = $clog2(NAPP),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_v,
  input  logic [AP_W-1:0] inc_app,
  input  logic            dec_v,
  input  logic [AP_W-1:0] dec_app,
  output logic [NAPP-1:0] full,
  output logic [NAPP-1:0] empty
);
  for (genvar a = 0; a < NAPP; a++) begin : g_app
    logic [CW-1:0] cnt;
    logic up, down;
    assign up   = inc_v && (inc_app == AP_W'(a));
    assign down = dec_v && (dec_app == AP_W'(a));

    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (up && !down) cnt <= cnt + CW'(1);
      else if (down && !up) cnt <= cnt - CW'(1);
    end

    assign full[a]  = (cnt == CW'(DEPTH));
    assign empty[a] = (cnt == '0);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      full[a] |-> !(up && !down));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      empty[a] |-> !down);
  end
endmodule

// File: rtl/task_dep_queue.sv
module task_dep_queue
  import tdq_pkg::*;
#(
  parameter int NAPP      = 2,
  parameter int SLOTS     = 8,
  parameter int APP_DEPTH = 4,
  parameter int NREG      = 16,
  parameter int PRIO_W    = 2,
  parameter int ID_W      = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_mode,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [$clog2(NAPP)-1:0]  in_app,
  input  logic [PRIO_W-1:0]        in_prio,
  input  logic [2*ID_W-1:0]        in_dep_ids,
  input  logic [1:0]               in_dep_vld,
  input  logic [NREG*ADDR_W-1:0]   in_base,
  input  logic [NREG*SIZE_W-1:0]   in_size,
  input  logic [NREG-1:0]          in_is_out,
  output logic [ID_W-1:0]          in_id,
  input  logic                     done_valid,
  input  logic [ID_W-1:0]          done_id,
  output logic                     disp_valid,
  input  logic                     disp_ready,
  output logic [ID_W-1:0]          disp_id,
  output logic [$clog2(NAPP)-1:0]  disp_app,
  input  logic [NAPP-1:0]          sync_req,
  output logic [NAPP-1:0]          sync_ack
);
  localparam int AP_W = $clog2(NAPP);
  localparam int SI_W = $clog2(SLOTS);
  localparam logic [SI_W-1:0] LAST_IDX = SI_W'(SLOTS - 1);

  // Slot state
  logic [SLOTS-1:0]  valid_q, running_q;
  logic [SLOTS-1:0]  wait_q  [SLOTS];
  logic [SLOTS-1:0]  older_q [SLOTS];
  logic [ID_W-1:0]   id_q    [SLOTS];
  logic [AP_W-1:0]   app_q   [SLOTS];
  logic [PRIO_W-1:0] prio_q  [SLOTS];
  addr_t             base_q  [SLOTS][NREG];
  size_t             len_q   [SLOTS][NREG];
  logic [NREG-1:0]   wr_q    [SLOTS];

  logic            scanning_q;
  logic [SI_W-1:0] scan_idx_q, new_slot_q;
  logic [ID_W-1:0] next_id_q;

  // Named events
  logic            accept, take, free_any, done_hit, scan_set, conf_hit;
  logic [SI_W-1:0] free_idx, done_idx, grant_idx;
  logic [SLOTS-1:0] done_mask, explicit_mask, ready_vec, grant;
  logic [NAPP-1:0] app_full, app_empty, app_busy;
  chk_mode_e       mode;

  addr_t in_base_a [NREG];
  size_t in_len_a  [NREG];
  addr_t cand_base [NREG];
  size_t cand_len  [NREG];
  addr_t res_base  [NREG];
  size_t res_len   [NREG];

  assign mode = chk_mode_e'(cfg_mode);

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      in_base_a[r] = in_base[r*ADDR_W +: ADDR_W];
      in_len_a[r]  = in_size[r*SIZE_W +: SIZE_W];
      cand_base[r] = base_q[new_slot_q][r];
      cand_len[r]  = len_q[new_slot_q][r];
      res_base[r]  = base_q[scan_idx_q][r];
      res_len[r]   = len_q[scan_idx_q][r];
    end
  end

  // Lowest free slot
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        free_any = 1'b1;
        free_idx = SI_W'(i);
      end
  end

  assign in_ready = !scanning_q && free_any && !app_full[in_app];
  assign accept   = in_valid && in_ready;
  assign in_id    = next_id_q;

  // Completion match: only issued tasks can finish
  always_comb begin
    done_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      done_mask[i] = done_valid && valid_q[i] && running_q[i] && (id_q[i] == done_id);
      if (done_mask[i]) done_idx = SI_W'(i);
    end
  end
  assign done_hit = |done_mask;

  // Explicit predecessors resolved against resident identifiers in one cycle
  always_comb begin
    for (int j = 0; j < SLOTS; j++)
      explicit_mask[j] = valid_q[j] && !done_mask[j] &&
        ((in_dep_vld[0] && id_q[j] == in_dep_ids[ID_W-1:0]) ||
         (in_dep_vld[1] && id_q[j] == in_dep_ids[2*ID_W-1:ID_W]));
  end

  tdq_conflict #(.NREG(NREG)) u_conflict (
    .new_base(cand_base), .new_len(cand_len), .new_wr(wr_q[new_slot_q]),
    .old_base(res_base),  .old_len(res_len),  .old_wr(wr_q[scan_idx_q]),
    .hit(conf_hit)
  );

  assign scan_set = scanning_q && valid_q[scan_idx_q] && (scan_idx_q != new_slot_q) &&
                    !done_mask[scan_idx_q] && conf_hit;

  always_comb begin
    for (int i = 0; i < SLOTS; i++)
      ready_vec[i] = valid_q[i] && !running_q[i] && (wait_q[i] == '0) &&
                     !(scanning_q && new_slot_q == SI_W'(i));
  end

  tdq_pick #(.SLOTS(SLOTS), .PRIO_W(PRIO_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(ready_vec), .prio(prio_q), .older(older_q),
    .grant(grant), .grant_idx(grant_idx), .any(disp_valid)
  );

  assign disp_id  = id_q[grant_idx];
  assign disp_app = app_q[grant_idx];
  assign take     = disp_valid && disp_ready;

  tdq_app_count #(.NAPP(NAPP), .DEPTH(APP_DEPTH)) u_count (
    .clk(clk), .rst_n(rst_n),
    .inc_v(accept), .inc_app(in_app),
    .dec_v(done_hit), .dec_app(app_q[done_idx]),
    .full(app_full), .empty(app_empty)
  );

  always_comb begin
    for (int a = 0; a < NAPP; a++) begin
      app_busy[a] = 1'b0;
      for (int i = 0; i < SLOTS; i++)
        if (valid_q[i] && app_q[i] == AP_W'(a)) app_busy[a] = 1'b1;
    end
  end
  assign sync_ack = sync_req & app_empty;

  // Control state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= '0;
      running_q  <= '0;
      scanning_q <= 1'b0;
      scan_idx_q <= '0;
      new_slot_q <= '0;
      next_id_q  <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        wait_q[i]  <= '0;
        older_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        wait_q[i] <= wait_q[i] & ~done_mask;
        if (done_mask[i]) begin
          valid_q[i]   <= 1'b0;
          running_q[i] <= 1'b0;
        end
        if (take && grant[i]) running_q[i] <= 1'b1;
        if (accept) older_q[i][free_idx] <= 1'b1;
        if (accept && free_idx == SI_W'(i)) begin
          valid_q[i]   <= 1'b1;
          running_q[i] <= 1'b0;
          older_q[i]   <= '0;
          wait_q[i]    <= (mode == CHK_EXPLICIT) ? explicit_mask : '0;
        end
        if (scan_set && new_slot_q == SI_W'(i))
          wait_q[i][scan_idx_q] <= 1'b1;
      end
      if (accept) next_id_q <= next_id_q + ID_W'(1);
      if (accept && mode == CHK_RUNTIME) begin
        scanning_q <= 1'b1;
        scan_idx_q <= '0;
        new_slot_q <= free_idx;
      end else if (scanning_q) begin
        scan_idx_q <= scan_idx_q + SI_W'(1);
        if (scan_idx_q == LAST_IDX) scanning_q <= 1'b0;
      end
    end
  end

  // Descriptor payload, no reset needed
  always_ff @(posedge clk) begin
    if (accept) begin
      id_q[free_idx]   <= next_id_q;
      app_q[free_idx]  <= in_app;
      prio_q[free_idx] <= in_prio;
      wr_q[free_idx]   <= in_is_out;
      for (int r = 0; r < NREG; r++) begin
        base_q[free_idx][r] <= in_base_a[r];
        len_q[free_idx][r]  <= in_len_a[r];
      end
    end
  end

  assert_scan_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scanning_q |-> !in_ready);
  assert_scan_slot_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scanning_q |-> !(disp_valid && grant_idx == new_slot_q));
  assert_grant_unblocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (wait_q[grant_idx] == '0) && valid_q[grant_idx] && !running_q[grant_idx]);
  assert_done_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> ((valid_q & $past(done_mask)) == '0));
  assert_id_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (next_id_q == $past(next_id_q) + ID_W'(1)));
  assert_issue_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !(disp_valid && disp_id == $past(disp_id) && running_q[grant_idx]));
  for (genvar a = 0; a < NAPP; a++) begin : g_sync_chk
    assert_sync_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sync_ack[a] |-> !app_busy[a]);
  end
endmodule

// File: tb/tb_task_dep_queue.sv
module tb_task_dep_queue;
  localparam int NAPP = 2, SLOTS = 8, APP_DEPTH = 4, NREG = 16, PRIO_W = 2, ID_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic in_valid = 1'b0, in_ready;
  logic [0:0] in_app = '0;
  logic [PRIO_W-1:0] in_prio = '0;
  logic [2*ID_W-1:0] in_dep_ids = '0;
  logic [1:0] in_dep_vld = '0;
  logic [NREG*32-1:0] in_base = '0;
  logic [NREG*16-1:0] in_size = '0;
  logic [NREG-1:0] in_is_out = '0;
  logic [ID_W-1:0] in_id;
  logic done_valid = 1'b0;
  logic [ID_W-1:0] done_id = '0;
  logic disp_valid, disp_ready = 1'b0;
  logic [ID_W-1:0] disp_id;
  logic [0:0] disp_app;
  logic [NAPP-1:0] sync_req = '0, sync_ack;

  int n_chk = 0, n_bad = 0, exp_id = 0;

  always #4 clk = ~clk;

  task_dep_queue #(.NAPP(NAPP), .SLOTS(SLOTS), .APP_DEPTH(APP_DEPTH), .NREG(NREG),
                   .PRIO_W(PRIO_W), .ID_W(ID_W)) dut (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr_regs();
    in_base = '0; in_size = '0; in_is_out = '0;
  endtask

  task automatic set_reg(input int r, input int base, input int len, input logic wr);
    in_base[r*32 +: 32] = base;
    in_size[r*16 +: 16] = len[15:0];
    in_is_out[r] = wr;
  endtask

  task automatic send(input int app, input int prio, input int mode,
                      input logic [1:0] dv, input int d0, input int d1, output int id);
    @(negedge clk);
    in_app = app[0:0]; in_prio = prio[PRIO_W-1:0]; cfg_mode = mode[1:0];
    in_dep_vld = dv; in_dep_ids = {d1[ID_W-1:0], d0[ID_W-1:0]};
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    id = int'(in_id);
    chk(id == (exp_id % 64), "R6 identifier", id, exp_id % 64);
    exp_id++;
    @(posedge clk); #1;
    in_valid = 1'b0;
    clr_regs();
  endtask

  task automatic wait_scan();
    repeat (SLOTS + 1) @(negedge clk);
  endtask

  task automatic take_disp(input int exp, input string tag);
    @(negedge clk); #1;
    chk(disp_valid && int'(disp_id) == exp, tag, disp_valid ? int'(disp_id) : -1, exp);
    disp_ready = disp_valid;
    @(posedge clk); #1;
    disp_ready = 1'b0;
  endtask

  task automatic expect_idle(input string tag);
    @(negedge clk); #1;
    chk(!disp_valid, tag, disp_valid ? int'(disp_id) : -1, -1);
  endtask

  task automatic complete(input int id);
    @(negedge clk);
    done_valid = 1'b1; done_id = id[ID_W-1:0];
    @(posedge clk); #1;
    done_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    sync_req = 2'b11; #1;
    chk(in_ready, "R11 ready after reset", in_ready, 1);
    chk(!disp_valid, "R11 no issue after reset", disp_valid, 0);
    chk(sync_ack == 2'b11, "R10 sync after reset", sync_ack, 3);
    sync_req = '0;
  endtask

  task automatic t_no_check();
    int a, b;
    set_reg(0, 'h100, 'h40, 1'b1);
    send(0, 1, 0, 2'b00, 0, 0, a);
    set_reg(0, 'h100, 'h40, 1'b1);
    send(0, 1, 0, 2'b00, 0, 0, b);
    take_disp(a, "R4 first unchecked");
    take_disp(b, "R4 overlapping unchecked issues at once");
    complete(a); complete(b);
  endtask

  task automatic t_runtime_bounds();
    int a, b, c, d;
    set_reg(0, 'h1000, 'h100, 1'b1);
    send(0, 1, 0, 2'b00, 0, 0, a);
    take_disp(a, "R4 producer issued");
    set_reg(0, 'h1100, 'h10, 1'b0);
    send(0, 1, 2, 2'b00, 0, 0, b); wait_scan();
    set_reg(0, 'h1000, 0, 1'b0);
    send(0, 1, 2, 2'b00, 0, 0, c); wait_scan();
    set_reg(0, 'h10FF, 1, 1'b0);
    send(0, 1, 2, 2'b00, 0, 0, d); wait_scan();
    @(negedge clk);
    in_app = 1'b0; #1;
    chk(!in_ready, "R7 full application stalls", in_ready, 0);
    in_app = 1'b1; #1;
    chk(in_ready, "R7 other application unaffected", in_ready, 1);
    take_disp(b, "R1 adjacent region does not overlap");
    take_disp(c, "R1 zero length never overlaps");
    expect_idle("R1 last byte overlap blocks");
    complete(a);
    take_disp(d, "R2 issues after predecessor completes");
    complete(b); complete(c); complete(d);
  endtask

  task automatic t_runtime_kinds();
    int e, f, g, cnt;
    set_reg(0, 'h2000, 'h20, 1'b0);
    send(1, 2, 0, 2'b00, 0, 0, e);
    set_reg(0, 'h2010, 'h20, 1'b0);
    send(1, 2, 2, 2'b00, 0, 0, f);
    cnt = 0;
    @(negedge clk); #1;
    while (!in_ready && cnt < 50) begin cnt++; @(negedge clk); #1; end
    chk(cnt == SLOTS, "R3 scan length", cnt, SLOTS);
    set_reg(3, 'h2018, 4, 1'b1);
    send(1, 2, 2, 2'b00, 0, 0, g); wait_scan();
    take_disp(e, "R2 reader issued");
    take_disp(f, "R2 input on input adds no wait");
    expect_idle("R2 writer waits for readers");
    complete(e);
    expect_idle("R2 writer still waits for second reader");
    complete(f);
    take_disp(g, "R2 writer released");
    complete(g);
  endtask

  task automatic t_explicit();
    int h, i, j;
    send(0, 1, 0, 2'b00, 0, 0, h);
    take_disp(h, "R5 predecessor issued");
    send(0, 1, 1, 2'b11, h, (h + 20) % 64, i);
    send(0, 1, 1, 2'b00, h, 0, j);
    take_disp(j, "R5 disabled identifiers add no wait");
    expect_idle("R5 named predecessor blocks");
    complete(h);
    take_disp(i, "R5 released after named predecessor");
    complete(i); complete(j);
  endtask

  task automatic t_priority();
    int k, l, m, n;
    send(0, 1, 0, 2'b00, 0, 0, k);
    send(1, 3, 0, 2'b00, 0, 0, l);
    send(1, 3, 0, 2'b00, 0, 0, m);
    send(0, 0, 0, 2'b00, 0, 0, n);
    take_disp(l, "R8 highest priority first");
    take_disp(m, "R8 equal priority oldest first");
    take_disp(k, "R8 middle priority");
    take_disp(n, "R8 lowest priority last");
    complete(k); complete(l); complete(m); complete(n);
  endtask

  task automatic t_completion();
    int q;
    send(1, 1, 0, 2'b00, 0, 0, q);
    @(negedge clk); sync_req = 2'b10; #1;
    chk(sync_ack == 2'b00, "R10 sync held while task resident", sync_ack, 0);
    complete(q);
    complete((q + 30) % 64);
    @(negedge clk); #1;
    chk(disp_valid && int'(disp_id) == q, "R9 completion of unissued task ignored",
        int'(disp_id), q);
    chk(sync_ack == 2'b00, "R9 count unchanged by ignored completion", sync_ack, 0);
    take_disp(q, "R12 issue");
    expect_idle("R12 not offered twice");
    complete(q);
    @(negedge clk); #1;
    chk(sync_ack == 2'b10, "R10 sync after last completion", sync_ack, 2);
    sync_req = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_no_check();
    t_runtime_bounds();
    t_runtime_kinds();
    t_explicit();
    t_priority();
    t_completion();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule